// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the fields of a fetched instruction into the control lines that steer a single-cycle datapath. It serves a small load/store instruction subset: register-to-register arithmetic and logic, word load, word store and branch-if-equal. It is purely combinational. Every output follows the current opcode, function field and ALU zero flag within the same cycle.

The ALU operation is chosen in two steps. First, the opcode is reduced to a 2-bit class: add, subtract, or "use the function field". Second, that class is combined with the function field to give a 3-bit ALU code. The next-PC select is the only output that depends on a runtime value. An internal branch signal is ANDed with the ALU zero flag, so the branch target is taken only when the compared operands are equal.

Top module: `ctl_decoder`

## Requirements
- R1: The decoder recognises exactly four opcodes: 000000 (register format), 100011 (load word), 101011 (store word) and 000100 (branch-if-equal).
- R2: For load and store, `alu_ctl` is 010 (add), and for branch-if-equal it is 110 (subtract), whatever the function field holds.
- R3: For register format, `alu_ctl` follows `funct`: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), 101010 gives 111 (set-less-than), and any other value gives 010.
- R4: `alu_src_imm` is 1 (sign-extended immediate operand) for load and store, and 0 (register operand) for every other opcode.
- R5: `mem_rd` is 1 only for load and `mem_wr` is 1 only for store. The two are never 1 together.
- R6: `pc_sel` is 1 exactly when the opcode is branch-if-equal and `alu_zero` is 1.
- R7: `reg_wr` is 1 for register format and load, and 0 for store and branch. `reg_dst` is 1 (rd field) only for register format. `mem_to_reg` is 1 only for load.
- R8: Any other opcode drives `reg_wr`, `mem_rd`, `mem_wr`, `pc_sel`, `alu_src_imm`, `reg_dst` and `mem_to_reg` to 0, and drives `alu_ctl` to 010, for any `funct` and `alu_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode field of the instruction |
| funct | input | 6 | Function field, used only for register format |
| alu_zero | input | 1 | ALU result-is-zero flag from the datapath |
| reg_dst | output | 1 | Destination register select: 1 = rd, 0 = rt |
| alu_src_imm | output | 1 | Second ALU operand: 1 = immediate, 0 = register |
| mem_to_reg | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| pc_sel | output | 1 | Next PC: 1 = branch target, 0 = sequential |
| alu_ctl | output | 3 | ALU operation code |

## Verification
The bench sweeps all 64 opcodes with several function values and both states of the zero flag. This catches a decoder that matches only part of the opcode bits, because such a decoder would also fire enables for unsupported opcodes. Branch-if-equal is driven with zero both low and high, so a next-PC select that ignores the flag would redirect the PC on an unequal compare. Load, store and branch are paired with register-format function codes, so a decoder that lets `funct` leak into non-register instructions would produce the wrong ALU operation there. An unrecognised function code under register format is also checked against the add fallback.

// File: rtl/ctl_decoder.sv
module ctl_decoder #(
  parameter int OP_W = 6,
  parameter int FN_W = 6,
  parameter int AC_W = 3
) (
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  input  logic            alu_zero,
  output logic            reg_dst,
  output logic            alu_src_imm,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            pc_sel,
  output logic [AC_W-1:0] alu_ctl
);
  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  localparam logic [AC_W-1:0] AC_AND = 3'b000;
  localparam logic [AC_W-1:0] AC_OR  = 3'b001;
  localparam logic [AC_W-1:0] AC_ADD = 3'b010;
  localparam logic [AC_W-1:0] AC_SUB = 3'b110;
  localparam logic [AC_W-1:0] AC_SLT = 3'b111;

  logic is_r, is_ld, is_st, is_br;
  logic [1:0] alu_cls;

  assign is_r  = (opcode == OP_RTYPE);
  assign is_ld = (opcode == OP_LOAD);
  assign is_st = (opcode == OP_STORE);
  assign is_br = (opcode == OP_BEQ);

  assign reg_dst     = is_r;
  assign alu_src_imm = is_ld | is_st;
  assign mem_to_reg  = is_ld;
  assign reg_wr      = is_r | is_ld;
  assign mem_rd      = is_ld;
  assign mem_wr      = is_st;
  assign pc_sel      = is_br & alu_zero;

  assign alu_cls = is_r ? CLS_FN : (is_br ? CLS_SUB : CLS_ADD);

  always_comb begin
    alu_ctl = AC_ADD;
    case (alu_cls)
      CLS_SUB: alu_ctl = AC_SUB;
      CLS_FN: begin
        case (funct)
          6'b100000: alu_ctl = AC_ADD;
          6'b100010: alu_ctl = AC_SUB;
          6'b100100: alu_ctl = AC_AND;
          6'b100101: alu_ctl = AC_OR;
          6'b101010: alu_ctl = AC_SLT;
          default:   alu_ctl = AC_ADD;
        endcase
      end
      default: alu_ctl = AC_ADD;
    endcase
  end
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
  input logic [5:0] opcode,
  input logic       alu_zero,
  input logic       reg_dst,
  input logic       alu_src_imm,
  input logic       mem_to_reg,
  input logic       reg_wr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       pc_sel,
  input logic [2:0] alu_ctl
);
  logic known;
  assign known = (opcode == 6'b000000) || (opcode == 6'b100011) ||
                 (opcode == 6'b101011) || (opcode == 6'b000100);

  always_comb begin
    AST_MEM_EXCLUSIVE: assert (!(mem_rd && mem_wr)); // R5
    AST_PC_NEEDS_ZERO: assert (!pc_sel || alu_zero); // R6
    AST_PC_ONLY_BEQ: assert (!pc_sel || opcode == 6'b000100); // R6
    AST_IMM_ONLY_MEM: assert (!alu_src_imm || mem_rd || mem_wr); // R4
    AST_LOAD_WRITEBACK: assert (!mem_rd || (reg_wr && mem_to_reg && !reg_dst)); // R7
    AST_UNKNOWN_QUIET: assert (known || (!reg_wr && !mem_rd && !mem_wr && !pc_sel && alu_ctl == 3'b010)); // R8
    AST_MEM_OP_ADDS: assert (!(mem_rd || mem_wr) || alu_ctl == 3'b010); // R2
  end
endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .opcode(opcode), .alu_zero(alu_zero), .reg_dst(reg_dst),
  .alu_src_imm(alu_src_imm), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_sel(pc_sel), .alu_ctl(alu_ctl)
);

// File: tb/tb_ctl_decoder.sv
module tb_ctl_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic alu_zero = 1'b0;
  logic reg_dst, alu_src_imm, mem_to_reg, reg_wr, mem_rd, mem_wr, pc_sel;
  logic [2:0] alu_ctl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_decoder dut (
    .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .reg_dst(reg_dst), .alu_src_imm(alu_src_imm), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_sel(pc_sel),
    .alu_ctl(alu_ctl)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%b fn=%b z=%0d actual=%0d expected=%0d",
               req, what, opcode, funct, alu_zero, act, exp);
    end
  endtask

  function automatic int fn_code(input logic [5:0] f);
    if (f == 6'd32) return 2;
    if (f == 6'd34) return 6;
    if (f == 6'd36) return 0;
    if (f == 6'd37) return 1;
    if (f == 6'd42) return 7;
    return 2;
  endfunction

  task automatic compare_all();
    int e_dst = 0, e_imm = 0, e_m2r = 0, e_rw = 0, e_mr = 0, e_mw = 0, e_pc = 0, e_alu = 2;
    string tag = "R8";
    if (opcode == 6'd0) begin
      tag = "R3"; e_dst = 1; e_rw = 1; e_alu = fn_code(funct);
    end else if (opcode == 6'd35) begin
      tag = "R2"; e_imm = 1; e_m2r = 1; e_rw = 1; e_mr = 1;
    end else if (opcode == 6'd43) begin
      tag = "R2"; e_imm = 1; e_mw = 1;
    end else if (opcode == 6'd4) begin
      tag = "R2"; e_alu = 6; e_pc = alu_zero ? 1 : 0;
    end
    check(tag, "alu_ctl", int'(alu_ctl), e_alu);
    check((tag == "R8") ? "R8" : "R4", "alu_src_imm", int'(alu_src_imm), e_imm);
    check((tag == "R8") ? "R8" : "R5", "mem_rd", int'(mem_rd), e_mr);
    check((tag == "R8") ? "R8" : "R5", "mem_wr", int'(mem_wr), e_mw);
    check((tag == "R8") ? "R8" : "R6", "pc_sel", int'(pc_sel), e_pc);
    check((tag == "R8") ? "R8" : "R7", "reg_wr", int'(reg_wr), e_rw);
    check((tag == "R8") ? "R8" : "R7", "reg_dst", int'(reg_dst), e_dst);
    check((tag == "R8") ? "R8" : "R7", "mem_to_reg", int'(mem_to_reg), e_m2r);
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
    @(posedge clk);
    opcode = op; funct = fn; alu_zero = z;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    logic [5:0] fn_list [8] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd0, 6'd63, 6'd33};
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(); // R7 R3: reset-state vector (register format, funct 0)
    // R1 R6: branch with zero low must not redirect, with zero high must
    apply(6'd4, 6'd32, 1'b0);
    apply(6'd4, 6'd32, 1'b1);
    // R3: each ALU function, plus unknown funct fallback
    for (int i = 0; i < 8; i++) apply(6'd0, fn_list[i], 1'b1);
    // R2 R4 R5: memory ops carrying R-format funct values
    apply(6'd35, 6'd34, 1'b1);
    apply(6'd43, 6'd42, 1'b0);
    // R1 R8: full opcode sweep
    for (int op = 0; op < 64; op++)
      for (int k = 0; k < 8; k++)
        for (int z = 0; z < 2; z++)
          apply(op[5:0], fn_list[k], z[0]);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule